// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block is the host side of a four-bit reverse channel on a parallel printer port that has already been switched into nibble mode. The peripheral returns data over four of its status lines, half a byte at a time, and the host paces each half with a two-step handshake. It lowers its host-busy line to ask for a nibble. It waits for the peripheral's acknowledge strobe to fall, then captures the four status lines and raises host-busy again. It then waits for the acknowledge strobe to return high before asking for the next nibble.

Two nibbles form one byte, which is offered on a valid/ready output. A new byte is not requested until the consumer has taken the current one. A tick input paces the timeouts. The first nibble of a byte is given a long idle allowance, because the peripheral may simply have nothing to send. Every other wait gets a short allowance, and missing one of those is a broken handshake. The two failures are reported on separate flags. An enable input starts and stops reception. The status inputs pass through a synchronizer before the state machine sees them, so the peripheral may drive them with no relation to the host clock.

Top module: `nibble_reverse_rx`

## Requirements
- R1: After reset, host_busy_n, sel_in_n and strobe_n are high, byte_valid is low, and both error flags are low.
- R2: sel_in_n and strobe_n stay high at all times.
- R3: While enable is high and no byte is held, host_busy_n goes low to ask for a nibble. Once ack_n is seen low, host_busy_n returns high and the four status lines are captured. After ack_n is seen high again, host_busy_n goes low for the second nibble.
- R4: Bit mapping of a captured nibble, using line levels with high = 1: fault_n goes to bit 0, select to bit 1, paper_out to bit 2 and busy to bit 3 for the first nibble. The second nibble uses the same order for bits 4 to 7.
- R5: After the second nibble's ack_n release, byte_valid goes high with the assembled byte on byte_data.
- R6: While byte_valid is high and byte_ready is low, byte_valid stays high, byte_data holds its value, and host_busy_n stays high. No new nibble is requested until the byte is accepted.
- R7: If FIRST_TICKS tick pulses arrive while waiting for the first nibble's ack_n to fall, err_idle rises one cycle after the last of them. host_busy_n is then high and err_idle stays set until enable goes low.
- R8: If STEP_TICKS tick pulses arrive during any other wait (either ack_n release, or the second nibble's ack_n fall), err_link rises and stays set until enable goes low. err_idle stays low in this case.
- R9: Dropping enable in the middle of a byte returns host_busy_n high on the next cycle without presenting a byte. The partial nibble is discarded, and the next byte is assembled fresh.
- R10: Only cycles with tick high count toward a timeout, and the count restarts at each wait. A wait that sees one tick fewer than its limit does not fail.
- R11: Clearing enable clears either error flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Reception allowed while high |
| tick | input | 1 | Timeout time base, one count per high cycle |
| ack_n | input | 1 | Peripheral acknowledge strobe, active low |
| fault_n | input | 1 | Status line carried into data bits 0 and 4 |
| select | input | 1 | Status line carried into data bits 1 and 5 |
| paper_out | input | 1 | Status line carried into data bits 2 and 6 |
| busy | input | 1 | Status line carried into data bits 3 and 7 |
| host_busy_n | output | 1 | Host handshake; low asks for a nibble |
| sel_in_n | output | 1 | Held high |
| strobe_n | output | 1 | Held high |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | byte_data holds a byte |
| byte_ready | input | 1 | Consumer accepts the byte when high together with byte_valid |
| err_idle | output | 1 | First-nibble wait expired |
| err_link | output | 1 | Handshake wait expired |

## Verification
The assertions assume that the peripheral changes the four data lines no later than the fall of ack_n, and holds them until host_busy_n rises. They also assume that ack_n is high whenever reception is enabled afresh, so that a stale strobe from an aborted byte is never taken as a new nibble. The bench's peripheral tasks always set the data lines in the same cycle that they lower ack_n, and release ack_n as soon as host_busy_n rises. Before enable is raised again, the bench returns ack_n high. Tick is held low during byte transfers, and it runs only in the timeout scenarios, where the expiry cycle is counted exactly.

// File: rtl/nibrx_pkg.sv
// Shared types for the nibble-mode reverse receiver.
// Assumes: status lines are already synchronized where these helpers are used.
package nibrx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,      // reception stopped, handshake line high
        ST_ASK_LO,   // first nibble requested, long timeout
        ST_REL_LO,   // first nibble captured, waiting for strobe release
        ST_ASK_HI,   // second nibble requested, short timeout
        ST_REL_HI,   // second nibble captured, waiting for strobe release
        ST_HOLD,     // byte offered to consumer
        ST_TOUT,     // idle timeout reported
        ST_LINKERR   // handshake timeout reported
    } rx_state_t;

    typedef struct packed {
        logic busy;
        logic paper_out;
        logic select;
        logic fault_n;
        logic ack_n;
    } port_status_t;

    localparam int STATUS_W = $bits(port_status_t);

    // Data nibble from the four status lines, lowest bit first as fault_n.
    function automatic logic [3:0] status_nibble(input port_status_t s);
        return {s.busy, s.paper_out, s.select, s.fault_n};
    endfunction

endpackage

// File: rtl/nibrx_sync.sv
// Multi-stage synchronizer for the peripheral status lines.
// Assumes: inputs are idle-high, so every stage resets to ones.
module nibrx_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= din;
                end
            end else begin : g_rest
                // Shift through the remaining stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= '1;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/nibrx_timer.sv
// Tick counter for handshake waits; selects the long or short limit.
// Assumes: restart is raised on every wait entry; the limit choice is
// constant within one wait.
module nibrx_timer #(
    parameter int LONG_TICKS  = 2000,
    parameter int SHORT_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic use_long,
    output logic expired
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Pick the final count for the current wait.
    always_comb begin
        last    = use_long ? LONG_LAST : SHORT_LAST;
        expired = tick && (cnt_q == last);
    end

    // Count tick pulses since the wait began.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)       cnt_q <= '0;
        else if (tick && !expired)   cnt_q <= cnt_q + 1'b1;
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (cnt_q <= LONG_LAST)); // R10
endmodule

// File: rtl/nibrx_fsm.sv
// Handshake sequencer: requests nibbles, captures them, offers the byte.
// Assumes: status and strobe inputs come from the synchronizer; the
// expiry input belongs to the wait in progress.
module nibrx_fsm
    import nibrx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  port_status_t st,
    input  logic         expired,
    input  logic         byte_ready,
    output logic         restart,
    output logic         use_long,
    output logic         host_busy_n,
    output logic [7:0]   byte_data,
    output logic         byte_valid,
    output logic         err_idle,
    output logic         err_link
);
    rx_state_t  state_q, state_d;
    logic [7:0] data_q;

    // Next-state decision for the handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (enable) state_d = ST_ASK_LO;
            ST_ASK_LO: if (!enable)        state_d = ST_OFF;
                       else if (!st.ack_n) state_d = ST_REL_LO;
                       else if (expired)   state_d = ST_TOUT;
            ST_REL_LO: if (!enable)        state_d = ST_OFF;
                       else if (st.ack_n)  state_d = ST_ASK_HI;
                       else if (expired)   state_d = ST_LINKERR;
            ST_ASK_HI: if (!enable)        state_d = ST_OFF;
                       else if (!st.ack_n) state_d = ST_REL_HI;
                       else if (expired)   state_d = ST_LINKERR;
            ST_REL_HI: if (!enable)        state_d = ST_OFF;
                       else if (st.ack_n)  state_d = ST_HOLD;
                       else if (expired)   state_d = ST_LINKERR;
            ST_HOLD:   if (byte_ready)     state_d = enable ? ST_ASK_LO : ST_OFF;
            ST_TOUT,
            ST_LINKERR: if (!enable)       state_d = ST_OFF;
            default:   state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Nibble capture on the falling acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state_q == ST_ASK_LO && state_d == ST_REL_LO) begin
            data_q[3:0] <= status_nibble(st);
        end else if (state_q == ST_ASK_HI && state_d == ST_REL_HI) begin
            data_q[7:4] <= status_nibble(st);
        end
    end

    // Output decode from the state.
    always_comb begin
        restart     = (state_d != state_q);
        use_long    = (state_q == ST_ASK_LO);
        host_busy_n = !(state_q == ST_ASK_LO || state_q == ST_ASK_HI);
        byte_valid  = (state_q == ST_HOLD);
        err_idle    = (state_q == ST_TOUT);
        err_link    = (state_q == ST_LINKERR);
        byte_data   = data_q;
    end

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data)); // R6
    AST_NO_ASK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> host_busy_n); // R6
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> host_busy_n); // R9
    AST_IDLE_FROM_ASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_idle) |-> $past(!host_busy_n)); // R7
    AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_idle && enable |=> err_idle); // R7
    AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_link && enable |=> err_link); // R8
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !byte_valid |=> !err_idle && !err_link); // R11
endmodule

// File: rtl/nibble_reverse_rx.sv
// Top of the nibble-mode reverse receiver: synchronizer, timer, sequencer.
// Assumes: the port is already in nibble mode; tick is a clk-domain pulse.
module nibble_reverse_rx
    import nibrx_pkg::*;
#(
    parameter int FIRST_TICKS = 2000,
    parameter int STEP_TICKS  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tick,
    input  logic       ack_n,
    input  logic       fault_n,
    input  logic       select,
    input  logic       paper_out,
    input  logic       busy,
    output logic       host_busy_n,
    output logic       sel_in_n,
    output logic       strobe_n,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    input  logic       byte_ready,
    output logic       err_idle,
    output logic       err_link
);
    port_status_t raw_st, sync_st;
    logic         restart, use_long, expired;

    // Gather the raw status lines.
    always_comb begin
        raw_st.busy      = busy;
        raw_st.paper_out = paper_out;
        raw_st.select    = select;
        raw_st.fault_n   = fault_n;
        raw_st.ack_n     = ack_n;
    end

    nibrx_sync #(.WIDTH(STATUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_st),
        .dout (sync_st)
    );

    nibrx_timer #(.LONG_TICKS(FIRST_TICKS), .SHORT_TICKS(STEP_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .use_long(use_long),
        .expired (expired)
    );

    nibrx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .st         (sync_st),
        .expired    (expired),
        .byte_ready (byte_ready),
        .restart    (restart),
        .use_long   (use_long),
        .host_busy_n(host_busy_n),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .err_idle   (err_idle),
        .err_link   (err_link)
    );

    // Lines unused in this mode stay inactive.
    assign sel_in_n = 1'b1;
    assign strobe_n = 1'b1;

    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_link) |-> !err_idle); // R8
endmodule

// File: tb/nibble_reverse_rx_test.sv
`timescale 1ns/1ps
module nibble_reverse_rx_test;
    logic clk = 1'b0;
    logic rst_n, enable, tick, ack_n, fault_n, select, paper_out, busy, byte_ready;
    logic host_busy_n, sel_in_n, strobe_n, byte_valid, err_idle, err_link;
    logic [7:0] byte_data;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    nibble_reverse_rx uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .ack_n(ack_n),
        .fault_n(fault_n), .select(select), .paper_out(paper_out), .busy(busy),
        .host_busy_n(host_busy_n), .sel_in_n(sel_in_n), .strobe_n(strobe_n),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .err_idle(err_idle), .err_link(err_link)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Wait at falling edges until host_busy_n reaches a level.
    task automatic wait_busy(input logic lvl, output int n);
        n = 0;
        while (host_busy_n !== lvl && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        while (byte_valid !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Peripheral returns one nibble and releases the strobe.
    task automatic give_nibble(input logic [3:0] v);
        int n;
        {busy, paper_out, select, fault_n} = v;
        ack_n = 1'b0;
        wait_busy(1'b1, n);
        ack_n = 1'b1;
    endtask

    task automatic give_byte(input logic [7:0] b);
        int n;
        wait_busy(1'b0, n);
        give_nibble(b[3:0]);
        wait_busy(1'b0, n);
        give_nibble(b[7:4]);
    endtask

    task automatic accept;
        byte_ready = 1'b1;
        @(negedge clk);
        byte_ready = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; enable = 1'b0; tick = 1'b0; ack_n = 1'b1; byte_ready = 1'b0;
        {busy, paper_out, select, fault_n} = 4'hF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_busy_n && sel_in_n && strobe_n, "R1 lines high",
              {host_busy_n, sel_in_n, strobe_n}, 3'b111);
        check(!byte_valid && !err_idle && !err_link, "R1 flags low",
              {byte_valid, err_idle, err_link}, 0);
    endtask

    task automatic t_byte(input logic [7:0] b);
        int n;
        enable = 1'b1;
        wait_busy(1'b0, n);
        check(n < 300, "R3 request issued", host_busy_n, 0);
        give_byte(b);
        wait_valid(n);
        check(byte_valid === 1'b1, "R5 byte valid", byte_valid, 1);
        check(byte_data === b, "R4 bit mapping", byte_data, b);
        check(sel_in_n && strobe_n, "R2 idle lines", {sel_in_n, strobe_n}, 3);
        accept();
    endtask

    task automatic t_hold;
        int n;
        enable = 1'b1;
        give_byte(8'hC3);
        wait_valid(n);
        repeat (12) begin
            @(negedge clk);
            if (!(byte_valid && host_busy_n && byte_data == 8'hC3)) n = -1;
        end
        check(n != -1, "R6 byte held, no request", byte_data, 8'hC3);
        accept();
        check(!byte_valid, "R6 accepted", byte_valid, 0);
        @(negedge clk);
        check(!host_busy_n, "R6 next request after accept", host_busy_n, 0);
    endtask

    task automatic t_idle_timeout;
        int n;
        enable = 1'b1;
        wait_busy(1'b0, n);
        tick = 1'b1;
        n = 0;
        while (!err_idle && n < 2100) begin
            @(negedge clk);
            n++;
        end
        tick = 1'b0;
        check(n == 2000, "R7 expiry cycle", n, 2000);
        check(host_busy_n && !err_link, "R7 line high, no link error",
              {host_busy_n, err_link}, 2'b10);
        repeat (5) @(negedge clk);
        check(err_idle, "R7 flag held", err_idle, 1);
        enable = 1'b0;
        @(negedge clk);
        check(!err_idle, "R11 flag cleared", err_idle, 0);
    endtask

    task automatic t_idle_boundary;
        int n;
        enable = 1'b1;
        wait_busy(1'b0, n);
        repeat (1999) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
        check(!err_idle, "R10 one tick short", err_idle, 0);
        give_nibble(4'h6);
        wait_busy(1'b0, n);
        give_nibble(4'h9);
        wait_valid(n);
        check(byte_data === 8'h96 && !err_idle, "R10 byte after long wait", byte_data, 8'h96);
        accept();
        enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_link_release;
        int n;
        enable = 1'b1;
        wait_busy(1'b0, n);
        {busy, paper_out, select, fault_n} = 4'h3;
        ack_n = 1'b0;
        wait_busy(1'b1, n);
        tick = 1'b1;
        n = 0;
        while (!err_link && n < 50) begin
            @(negedge clk);
            n++;
        end
        tick = 1'b0;
        check(n == 6, "R8 release timeout", n, 6);
        check(!err_idle && host_busy_n, "R8 error kind", {err_idle, host_busy_n}, 1);
        ack_n = 1'b1;
        enable = 1'b0;
        @(negedge clk);
        check(!err_link, "R11 link cleared", err_link, 0);
    endtask

    task automatic t_link_second;
        int n;
        enable = 1'b1;
        wait_busy(1'b0, n);
        give_nibble(4'hA);
        wait_busy(1'b0, n);
        tick = 1'b1;
        n = 0;
        while (!err_link && n < 50) begin
            @(negedge clk);
            n++;
        end
        tick = 1'b0;
        check(n == 6, "R8 second nibble timeout", n, 6);
        check(!byte_valid, "R8 no byte", byte_valid, 0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_abort;
        int n;
        enable = 1'b1;
        wait_busy(1'b0, n);
        give_nibble(4'hE);
        wait_busy(1'b0, n);
        enable = 1'b0;
        @(negedge clk);
        check(host_busy_n, "R9 released on stop", host_busy_n, 1);
        repeat (6) @(negedge clk);
        check(!byte_valid && host_busy_n, "R9 no byte", {byte_valid, host_busy_n}, 1);
        enable = 1'b1;
        give_byte(8'h5A);
        wait_valid(n);
        check(byte_data === 8'h5A, "R9 fresh byte", byte_data, 8'h5A);
        accept();
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #750000;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_byte(8'hA5);
        t_byte(8'h3C);
        t_byte(8'h00);
        t_byte(8'hFF);
        t_byte(8'h81);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        t_hold();
        enable = 1'b0;
        repeat (3) @(negedge clk);
        t_idle_timeout();
        t_idle_boundary();
        t_link_release();
        t_link_second();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule